// File: doc/BRIEF.md
# SPI Flash Slave Command Engine

This block is a device-side model of a small serial NOR flash that answers on an SPI port. A host frames each instruction with an active-low chip select, clocks bytes in mode 0 (data sampled on the rising clock edge, driven on the falling edge, most significant bit first), and reads answers back on the data-out line. Inside are a byte array sized by parameters, a page buffer, a write-enable latch, a status byte and a deep-sleep state.

Array changes follow flash rules. A program operation can only clear bits. An erase returns bytes to FFh. Every program, erase or status write must be armed by a separate write-enable instruction, and the latch disarms itself when the operation finishes. The internal operation runs for at least a programmable number of clock cycles. It keeps running after chip select goes high, and the host polls the status byte until the busy flag drops.

The SPI pins are sampled with the system clock, so the serial clock must be several times slower than `clk`. The memory size, page size and sector size must be powers of two.

Top module: `spi_flash_engine`

## Requirements
- R1: SPI mode 0 framing. A bit is captured on each rising `spi_sck` edge and `spi_miso` changes after falling edges, MSB first. `spi_miso` is 0 while chip select is high.
- R2: Read (03h) takes a 3-byte address, MSB first, whose low bits select the byte. Data bytes stream out from the 5th byte of the frame onward, with the address incrementing and wrapping from the last byte to byte 0.
- R3: Status read (05h) returns the status byte from the 2nd byte on, repeating. Bit 0 is busy, bit 1 is the write-enable latch, and bits 7:2 are a user field. Enable-set (06h) sets the latch and enable-clear (04h) clears it. Both clear to 00h at reset.
- R4: Page program (02h), sector erase (D8h), chip erase (C7h) and status write (01h, which loads bits 7:2 from its 2nd byte) are ignored unless the write-enable latch is set when the frame ends.
- R5: Programming stores old AND new in each addressed byte, so a bit can go from 1 to 0 but never from 0 to 1.
- R6: Sector erase sets every byte of the sector holding the given address to FFh and leaves other sectors untouched. Chip erase sets the whole array to FFh.
- R7: While an operation runs, status bit 0 reads 1. It stays 1 after chip select rises. When the operation ends, bit 0 returns to 0 and the write-enable latch clears.
- R8: While busy, every instruction except status read is ignored. That includes reads, which return 00h, and a second program.
- R9: An instruction takes effect only if chip select rises after a whole number of bytes. A frame cut off mid-byte changes nothing.
- R10: Program data bytes start at the given address, wrap to the start of the same page past its end, and never touch another page. If more bytes arrive than a page holds, the last page-size bytes win.
- R11: After power-down (B9h), every instruction except wake is ignored, including status read and read, which return 00h.
- R12: Wake (ABh) leaves power-down. From the 5th byte of its frame it returns the signature 13h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select framing one instruction |
| spi_mosi | input | 1 | Serial data into the engine |
| spi_miso | output | 1 | Registered serial data out of the engine |

## Verification
The embedded properties watch, on every cycle, the rules on how an internal operation may start and end. It may start only at a byte-aligned frame end, only with the latch armed and only outside power-down. Its end clears the latch. Entry to and exit from power-down must each follow the matching instruction. The effects on the array can only be shown by the bench's scenarios, which read bytes back after each operation: AND-only programming, the extent of an erase, page wrap with last-bytes-win, streaming read wrap, instructions ignored while busy or asleep, and frames discarded mid-byte.

// File: rtl/spif_pkg.sv
package spif_pkg;
  localparam logic [7:0] OP_STAT_WR   = 8'h01;
  localparam logic [7:0] OP_PROG      = 8'h02;
  localparam logic [7:0] OP_READ      = 8'h03;
  localparam logic [7:0] OP_WEN_CLR   = 8'h04;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_WEN_SET   = 8'h06;
  localparam logic [7:0] OP_WAKE      = 8'hAB;
  localparam logic [7:0] OP_SLEEP     = 8'hB9;
  localparam logic [7:0] OP_ERASE_ALL = 8'hC7;
  localparam logic [7:0] OP_ERASE_SEC = 8'hD8;
  localparam logic [7:0] SIG_BYTE     = 8'h13;

  typedef enum logic [2:0] {
    CY_IDLE,
    CY_PRD,
    CY_PWR,
    CY_ERASE,
    CY_WAIT
  } cyc_e;
endpackage

// File: rtl/spif_link.sv
module spif_link (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck_i,
  input  logic       csn_i,
  input  logic       mosi_i,
  input  logic [7:0] tx_byte,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       frame_end,
  output logic       frame_aligned,
  output logic       miso_o
);
  logic [2:0] sck_q, csn_q;
  logic [1:0] mosi_q;
  logic [2:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh;
  logic       sel, sck_rise, sck_fall, cs_rise;

  assign sel      = ~csn_q[1];
  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign sck_fall = ~sck_q[1] & sck_q[2];
  assign cs_rise  = csn_q[1] & ~csn_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= '0;
      csn_q  <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck_i};
      csn_q  <= {csn_q[1:0], csn_i};
      mosi_q <= {mosi_q[0], mosi_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt       <= '0;
      rx_sh         <= '0;
      rx_valid      <= 1'b0;
      rx_byte       <= '0;
      tx_sh         <= '0;
      miso_o        <= 1'b0;
      frame_end     <= 1'b0;
      frame_aligned <= 1'b0;
    end else begin
      rx_valid      <= 1'b0;
      frame_end     <= cs_rise;
      frame_aligned <= cs_rise && (bit_cnt == 3'd0);
      if (!sel) begin
        bit_cnt <= '0;
        miso_o  <= 1'b0;
      end else begin
        if (sck_rise) begin
          rx_sh   <= {rx_sh[6:0], mosi_q[1]};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            rx_valid <= 1'b1;
            rx_byte  <= {rx_sh[6:0], mosi_q[1]};
          end
        end
        if (sck_fall) begin
          if (bit_cnt == 3'd0) begin
            miso_o <= tx_byte[7];
            tx_sh  <= {tx_byte[6:0], 1'b0};
          end else begin
            miso_o <= tx_sh[7];
            tx_sh  <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  assert_miso_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !miso_o);
  assert_rx_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/spif_array.sv
module spif_array #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spif_ctrl.sv
module spif_ctrl
  import spif_pkg::*;
#(
  parameter int MEM_BYTES    = 512,
  parameter int PAGE_BYTES   = 16,
  parameter int SECTOR_BYTES = 128,
  parameter int T_PROG       = 300,
  parameter int T_SERASE     = 600,
  parameter int T_BERASE     = 1200,
  parameter int T_STAT       = 100,
  parameter int CNT_W        = 16,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int SW = $clog2(SECTOR_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          frame_end,
  input  logic          frame_aligned,
  output logic [7:0]    tx_byte,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] mem_raddr,
  input  logic [7:0]    mem_rdata
);
  localparam logic [AW-1:0] PG_LAST  = AW'(PAGE_BYTES - 1);
  localparam logic [AW-1:0] SEC_LAST = AW'(SECTOR_BYTES - 1);
  localparam logic [AW-1:0] MEM_LAST = AW'(MEM_BYTES - 1);

  cyc_e              cyc;
  logic [2:0]        nbytes;
  logic [7:0]        opcode;
  logic              op_ok, wel, dp, busy, buf_wr;
  logic [5:0]        ustat, ustat_in;
  logic [AW-1:0]     addr_q, addr_next, rd_addr, base, last, idx;
  logic [PW-1:0]     pptr;
  logic [PAGE_BYTES-1:0] pvalid;
  logic [7:0]        pbuf [PAGE_BYTES];
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        status;

  assign busy      = (cyc != CY_IDLE);
  assign status    = {ustat, wel, busy};
  assign addr_next = AW'({addr_q, rx_byte});
  assign buf_wr    = rx_valid && (nbytes >= 3'd4) && op_ok && (opcode == OP_PROG);

  always_ff @(posedge clk) begin
    if (buf_wr) pbuf[pptr] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nbytes <= '0;  opcode <= '0;  op_ok <= 1'b0;  addr_q <= '0;
      ustat_in <= '0; rd_addr <= '0; pptr <= '0;    pvalid <= '0;
      wel <= 1'b0;   dp <= 1'b0;    ustat <= '0;   cyc <= CY_IDLE;
      cnt <= '0;     idx <= '0;     base <= '0;    last <= '0;
    end else begin
      if (rx_valid) begin
        if (nbytes != 3'd7) nbytes <= nbytes + 3'd1;
        if (nbytes == 3'd0) begin
          opcode <= rx_byte;
          op_ok  <= dp ? (rx_byte == OP_WAKE) : busy ? (rx_byte == OP_STAT_RD) : 1'b1;
          if (!busy && !dp) pvalid <= '0;
        end else if (nbytes <= 3'd3) begin
          addr_q <= addr_next;
        end
        if (nbytes == 3'd1) ustat_in <= rx_byte[7:2];
        if (nbytes == 3'd3) begin
          rd_addr <= addr_next;
          pptr    <= addr_next[PW-1:0];
        end
        if (buf_wr) begin
          pvalid[pptr] <= 1'b1;
          pptr         <= pptr + 1'b1;
        end
        if (nbytes >= 3'd4 && opcode == OP_READ) rd_addr <= rd_addr + 1'b1;
      end

      if (frame_end) begin
        nbytes <= '0;
        if (frame_aligned && op_ok && nbytes != 3'd0) begin
          case (opcode)
            OP_WEN_SET: wel <= 1'b1;
            OP_WEN_CLR: wel <= 1'b0;
            OP_SLEEP:   dp  <= 1'b1;
            OP_WAKE:    dp  <= 1'b0;
            OP_STAT_WR: if (wel && nbytes >= 3'd2) begin
              ustat <= ustat_in;
              cyc   <= CY_WAIT;
              cnt   <= CNT_W'(T_STAT - 1);
            end
            OP_PROG: if (wel && nbytes >= 3'd5) begin
              cyc  <= CY_PRD;
              cnt  <= CNT_W'(T_PROG - 1);
              base <= {addr_q[AW-1:PW], {PW{1'b0}}};
              last <= PG_LAST;
              idx  <= '0;
            end
            OP_ERASE_SEC: if (wel && nbytes >= 3'd4) begin
              cyc  <= CY_ERASE;
              cnt  <= CNT_W'(T_SERASE - 1);
              base <= {addr_q[AW-1:SW], {SW{1'b0}}};
              last <= SEC_LAST;
              idx  <= '0;
            end
            OP_ERASE_ALL: if (wel) begin
              cyc  <= CY_ERASE;
              cnt  <= CNT_W'(T_BERASE - 1);
              base <= '0;
              last <= MEM_LAST;
              idx  <= '0;
            end
            default: ;
          endcase
        end
      end

      if (busy && cnt != '0) cnt <= cnt - 1'b1;
      unique case (cyc)
        CY_IDLE:  ;
        CY_PRD:   cyc <= CY_PWR;
        CY_PWR: begin
          idx <= idx + 1'b1;
          cyc <= (idx == last) ? CY_WAIT : CY_PRD;
        end
        CY_ERASE: begin
          idx <= idx + 1'b1;
          if (idx == last) cyc <= CY_WAIT;
        end
        CY_WAIT: if (cnt == '0) begin
          cyc <= CY_IDLE;
          wel <= 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    mem_waddr = base + idx;
    mem_raddr = (cyc == CY_PRD) ? base + idx : rd_addr;
    mem_we    = ((cyc == CY_PWR) && pvalid[idx[PW-1:0]]) || (cyc == CY_ERASE);
    mem_wdata = (cyc == CY_ERASE) ? 8'hFF : (mem_rdata & pbuf[idx[PW-1:0]]);
  end

  always_comb begin
    tx_byte = 8'h00;
    if (op_ok) begin
      case (opcode)
        OP_STAT_RD: tx_byte = status;
        OP_READ:    if (nbytes >= 3'd4) tx_byte = mem_rdata;
        OP_WAKE:    if (nbytes >= 3'd4) tx_byte = SIG_BYTE;
        default:    tx_byte = 8'h00;
      endcase
    end
  end

  assert_start_armed_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel));
  assert_start_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(frame_aligned));
  assert_wel_drop_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel);
  assert_no_start_asleep_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(dp));
  assert_sleep_entry_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(dp) |-> $past(opcode) == OP_SLEEP);
  assert_wake_exit_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(dp) |-> $past(opcode) == OP_WAKE);
endmodule

// File: rtl/spi_flash_engine.sv
module spi_flash_engine #(
  parameter int MEM_BYTES    = 512,
  parameter int PAGE_BYTES   = 16,
  parameter int SECTOR_BYTES = 128,
  parameter int T_PROG       = 300,
  parameter int T_SERASE     = 600,
  parameter int T_BERASE     = 1200,
  parameter int T_STAT       = 100,
  parameter int CNT_W        = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  localparam int AW = $clog2(MEM_BYTES);

  logic          rx_valid, frame_end, frame_aligned, mem_we;
  logic [7:0]    rx_byte, tx_byte, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_waddr, mem_raddr;

  spif_link u_link (
    .clk, .rst,
    .sck_i(spi_sck), .csn_i(spi_cs_n), .mosi_i(spi_mosi),
    .tx_byte, .rx_valid, .rx_byte, .frame_end, .frame_aligned,
    .miso_o(spi_miso)
  );

  spif_ctrl #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
    .T_PROG(T_PROG), .T_SERASE(T_SERASE), .T_BERASE(T_BERASE),
    .T_STAT(T_STAT), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk, .rst, .rx_valid, .rx_byte, .frame_end, .frame_aligned,
    .tx_byte, .mem_we, .mem_waddr, .mem_wdata, .mem_raddr, .mem_rdata
  );

  spif_array #(.DEPTH(MEM_BYTES)) u_array (
    .clk, .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: tb/spi_flash_engine_bench.sv
module spi_flash_engine_bench;
  localparam int CLK_P = 10;
  localparam int HALF  = 8 * CLK_P;

  logic clk = 1'b0, rst = 1'b1;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;

  logic [7:0] txb [0:39];
  logic [7:0] rxb [0:39];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  spi_flash_engine #(
    .MEM_BYTES(512), .PAGE_BYTES(16), .SECTOR_BYTES(128),
    .T_PROG(3000), .T_SERASE(3000), .T_BERASE(4000), .T_STAT(1500), .CNT_W(16)
  ) u_spi_flash_engine (
    .clk, .rst, .spi_sck, .spi_cs_n, .spi_mosi, .spi_miso
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic xfer(input int nb, input int extra_bits);
    spi_cs_n = 1'b0;
    #(HALF);
    for (int i = 0; i < nb; i++) begin
      for (int b = 7; b >= 0; b--) begin
        spi_mosi = txb[i][b];
        #(HALF);
        rxb[i][b] = spi_miso;
        spi_sck = 1'b1;
        #(HALF);
        spi_sck = 1'b0;
      end
    end
    for (int b = 0; b < extra_bits; b++) begin
      spi_mosi = 1'b1;
      #(HALF);
      spi_sck = 1'b1;
      #(HALF);
      spi_sck = 1'b0;
    end
    #(HALF);
    spi_cs_n = 1'b1;
    #(4*HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    txb[0] = op;
    xfer(1, 0);
  endtask

  task automatic rdsr(output logic [7:0] s);
    txb[0] = 8'h05; txb[1] = 8'h00;
    xfer(2, 0);
    s = rxb[1];
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    s = 8'h01;
    for (int p = 0; p < 100 && s[0]; p++) rdsr(s);
  endtask

  task automatic set_addr(input logic [7:0] op, input logic [23:0] a);
    txb[0] = op; txb[1] = a[23:16]; txb[2] = a[15:8]; txb[3] = a[7:0];
  endtask

  task automatic prog_fill(input logic [23:0] a, input int n, input logic [7:0] v);
    set_addr(8'h02, a);
    for (int i = 0; i < n; i++) txb[4+i] = v;
    xfer(4 + n, 0);
  endtask

  task automatic rd(input logic [23:0] a, input int n);
    set_addr(8'h03, a);
    for (int i = 0; i < n; i++) txb[4+i] = 8'h00;
    xfer(4 + n, 0);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    check("R1 idle miso", {7'd0, spi_miso}, 8'h00);
    rdsr(s);
    check("R3 reset status", s, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] s;
    cmd1(8'hC7);
    rdsr(s);
    check("R4 erase without latch", s, 8'h00);
    cmd1(8'h06);
    rdsr(s);
    check("R3 latch set", s, 8'h02);
    cmd1(8'h04);
    rdsr(s);
    check("R3 latch clear", s, 8'h00);
  endtask

  task automatic t_chip_erase();
    logic [7:0] s;
    cmd1(8'h06);
    cmd1(8'hC7);
    rdsr(s);
    check("R7 busy after cs high", s, 8'h03);
    wait_idle();
    rdsr(s);
    check("R7 end clears latch", s, 8'h00);
    rd(24'h000000, 2);
    check("R6 chip erase byte0", rxb[4], 8'hFF);
    check("R6 chip erase byte1", rxb[5], 8'hFF);
    rd(24'h0001FE, 2);
    check("R6 chip erase top", rxb[5], 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] s;
    prog_fill(24'h000020, 1, 8'hA5);
    rd(24'h000020, 1);
    check("R4 program without latch", rxb[4], 8'hFF);
    cmd1(8'h06);
    prog_fill(24'h000020, 1, 8'hA5);
    rdsr(s);
    check("R7 program busy", s, 8'h03);
    wait_idle();
    rd(24'h000020, 1);
    check("R5 first program", rxb[4], 8'hA5);
    cmd1(8'h06);
    prog_fill(24'h000020, 1, 8'h3C);
    wait_idle();
    rd(24'h000020, 1);
    check("R5 AND on reprogram", rxb[4], 8'h24);
  endtask

  task automatic t_read_wrap();
    cmd1(8'h06);
    prog_fill(24'h0001FF, 1, 8'h5A);
    wait_idle();
    cmd1(8'h06);
    prog_fill(24'h000000, 1, 8'h11);
    wait_idle();
    rd(24'h0001FF, 2);
    check("R2 last byte", rxb[4], 8'h5A);
    check("R2 wrap to zero", rxb[5], 8'h11);
  endtask

  task automatic t_page_wrap();
    logic [7:0] exp_pg [0:15];
    for (int k = 0; k < 20; k++) exp_pg[(14 + k) % 16] = 8'(8'h60 + k);
    cmd1(8'h06);
    set_addr(8'h02, 24'h00004E);
    for (int k = 0; k < 20; k++) txb[4+k] = 8'(8'h60 + k);
    xfer(24, 0);
    wait_idle();
    rd(24'h000040, 16);
    for (int i = 0; i < 16; i++) check($sformatf("R10 page byte %0d", i), rxb[4+i], exp_pg[i]);
    rd(24'h00003F, 1);
    check("R10 below page", rxb[4], 8'hFF);
    rd(24'h000050, 1);
    check("R10 above page", rxb[4], 8'hFF);
  endtask

  task automatic t_sector();
    logic [7:0] s;
    cmd1(8'h06);
    prog_fill(24'h000070, 16, 8'h00);
    wait_idle();
    cmd1(8'h06);
    prog_fill(24'h000080, 16, 8'h00);
    wait_idle();
    cmd1(8'h06);
    set_addr(8'hD8, 24'h000082);
    xfer(4, 0);
    rdsr(s);
    check("R7 sector erase busy", s, 8'h03);
    wait_idle();
    rd(24'h00007C, 8);
    for (int i = 0; i < 4; i++) check("R6 previous sector kept", rxb[4+i], 8'h00);
    for (int i = 4; i < 8; i++) check("R6 sector erased", rxb[4+i], 8'hFF);
    rd(24'h000020, 1);
    check("R6 far byte kept", rxb[4], 8'h24);
  endtask

  task automatic t_busy();
    logic [7:0] s;
    cmd1(8'h06);
    prog_fill(24'h000060, 1, 8'h0F);
    rd(24'h000020, 1);
    check("R8 read while busy", rxb[4], 8'h00);
    prog_fill(24'h000061, 1, 8'h00);
    wait_idle();
    rdsr(s);
    check("R8 status after", s, 8'h00);
    rd(24'h000060, 2);
    check("R8 first program done", rxb[4], 8'h0F);
    check("R8 second program ignored", rxb[5], 8'hFF);
  endtask

  task automatic t_midbyte();
    logic [7:0] s;
    txb[0] = 8'h06;
    xfer(1, 4);
    rdsr(s);
    check("R9 partial enable ignored", s, 8'h00);
    cmd1(8'h06);
    txb[0] = 8'h04;
    xfer(1, 3);
    rdsr(s);
    check("R9 partial clear ignored", s, 8'h02);
    cmd1(8'h04);
  endtask

  task automatic t_stat_write();
    logic [7:0] s;
    cmd1(8'h06);
    txb[0] = 8'h01; txb[1] = 8'hFC;
    xfer(2, 0);
    wait_idle();
    rdsr(s);
    check("R1 R3 user field", s, 8'hFC);
    txb[0] = 8'h01; txb[1] = 8'hF0;
    xfer(2, 0);
    rdsr(s);
    check("R4 status write without latch", s, 8'hFC);
    cmd1(8'h06);
    txb[0] = 8'h01; txb[1] = 8'h00;
    xfer(2, 0);
    wait_idle();
    rdsr(s);
    check("R3 user field cleared", s, 8'h00);
  endtask

  task automatic t_sleep();
    logic [7:0] s;
    cmd1(8'h06);
    cmd1(8'hB9);
    rdsr(s);
    check("R11 status asleep", s, 8'h00);
    cmd1(8'h04);
    rd(24'h000020, 1);
    check("R11 read asleep", rxb[4], 8'h00);
    txb[0] = 8'hAB;
    for (int i = 1; i < 6; i++) txb[i] = 8'h00;
    xfer(6, 0);
    check("R12 dummy byte", rxb[3], 8'h00);
    check("R12 signature", rxb[4], 8'h13);
    check("R12 signature repeat", rxb[5], 8'h13);
    rdsr(s);
    check("R11 R12 awake latch kept", s, 8'h02);
    cmd1(8'h04);
  endtask

  initial begin
    #(CLK_P*190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    #(CLK_P*5);
    rst = 1'b0;
    #(CLK_P*10);
    t_reset();
    t_latch();
    t_chip_erase();
    t_program();
    t_read_wrap();
    t_page_wrap();
    t_sector();
    t_busy();
    t_midbyte();
    t_stat_write();
    t_sleep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule